// File: doc/BRIEF.md
# Link Power and Reference-Watch Controller

This controller sits beside a serializer/deserializer datapath and its clock multiplier. It decides, from two mode pins and from activity on the reference clock, whether the multiplier, its internal bias, and the serial drivers and receivers are on. It also says when received words may be trusted, drives the enable of the parallel pins from a direction pin, and shapes the parallel clock output after a wake-up. It runs on a free-running always-on clock that has no relation to the reference. The reference, the mode pins and the direction pin are each brought into that clock domain through two-flop synchronizers.

There are two ways to stop the link. A zero code on the mode pins is a full power-down that turns off the bias as well. A stalled reference, held high or held low, is a light stop that keeps the bias alive. The start-up wait after a light stop is shorter than the wait after a full power-down.

The FSM has five states. PM_OFF is full power-down. PM_LOCK_COLD is the long wait after PM_OFF. PM_LOCK_WARM is the short wait after a stall. PM_RUN is normal operation. PM_REF_STOP is the light stop. The transitions are as follows. A zero mode code from any state goes to PM_OFF. PM_OFF goes to PM_LOCK_COLD when the mode is nonzero and the reference is active. Either lock state goes to PM_RUN when its timer expires. Either lock state, and PM_RUN, go to PM_REF_STOP when the reference goes idle. PM_REF_STOP goes to PM_LOCK_WARM on reference activity.

Top module: `pmc_top`

## Requirements
- R1: A mode code of 2'b00 on `mode_pins` drives `pll_en`, `pll_bias_en`, `sio_en`, `data_valid` and `par_oe` low within 4 clock cycles, whatever the reference is doing. Reset leaves the block in this power-down state.
- R2: A nonzero mode code while the reference toggles raises `pll_en`, `pll_bias_en` and `sio_en` together.
- R3: After a full power-down, `data_valid` rises exactly COLD_WAIT+1 cycles after `pll_en` rises.
- R4: When the reference shows no edge for IDLE_LIMIT cycles, the block drops `pll_en`, `sio_en` and `data_valid` and keeps `pll_bias_en` high. This happens whether the reference stalls high or low, and never earlier than IDLE_LIMIT cycles after the last edge.
- R5: The first reference edge after a stall raises `pll_en` again, and `data_valid` follows exactly WARM_WAIT+1 cycles later. WARM_WAIT is smaller than COLD_WAIT.
- R6: Coming out of power-down with a nonzero mode but a stalled reference, the block stays fully off until the reference toggles. It then takes the COLD_WAIT path.
- R7: On leaving power-down, `par_clk_out` is low for PULSE_CYC cycles starting in the cycle where `pll_en` rises, and is then high. While `data_valid` is high it equals `par_clk_in`. In every other case it is high, and a warm relock gives no low pulse.
- R8: `par_oe` is high exactly when the synchronized `par_dir` is low and the block is not in power-down. It follows `par_dir` two cycles later.
- R9: `data_valid` is never high unless `pll_en` and `sio_en` are both high.
- R10: Changing between nonzero mode codes in PM_RUN leaves `data_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pins | input | 2 | Mode code; 2'b00 means full power-down |
| ref_clk | input | 1 | Reference clock, watched for edges |
| par_dir | input | 1 | Direction pin; low means parallel pins are driven |
| par_clk_in | input | 1 | Recovered parallel clock from the datapath |
| pll_en | output | 1 | Clock multiplier enable |
| pll_bias_en | output | 1 | Internal reference/bias enable, low only in power-down |
| sio_en | output | 1 | Serial driver enable and receiver enable; drivers high-impedance when low |
| data_valid | output | 1 | Received words may be passed on |
| par_oe | output | 1 | Parallel output drive enable |
| par_clk_out | output | 1 | Shaped parallel clock output |

## Verification
The checker tests these properties on every cycle:
- Power-down keeps the link and the multiplier off, and holds the parallel clock high.
- Valid data implies a running link.
- Every drop of `pll_en` with the bias kept on is preceded by an idle reference.
- The output enable agrees with the direction pin from two cycles earlier.
- A rise of `data_valid` comes only out of a lock wait.

Only the bench scenarios can show the following:
- The exact cold and warm wait lengths.
- The length of the low pulse on the parallel clock.
- That a stall is detected at both held levels and is not detected too early.
- That a stalled reference blocks the exit from power-down.
- That changing the mode code while running is harmless.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_OFF       = 3'd0,
        PM_LOCK_COLD = 3'd1,
        PM_LOCK_WARM = 3'd2,
        PM_RUN       = 3'd3,
        PM_REF_STOP  = 3'd4
    } pm_state_t;

    localparam logic [1:0] MODE_POWER_DOWN = 2'b00;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int         WIDTH   = 1,
    parameter logic [0:0] RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= {WIDTH{RST_VAL}};
            stable_q <= {WIDTH{RST_VAL}};
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;
endmodule

// File: rtl/pmc_ref_monitor.sv
module pmc_ref_monitor #(
    parameter int IDLE_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic ref_active
);
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

    logic             ref_s;
    logic             ref_prev_q;
    logic             ref_edge;
    logic [CNT_W-1:0] quiet_q;

    pmc_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_ref_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ref_clk),
        .q    (ref_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_prev_q <= 1'b0;
        else        ref_prev_q <= ref_s;
    end

    assign ref_edge = ref_s ^ ref_prev_q;

    // Cycles since the last edge, saturating at the idle limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                quiet_q <= LIMIT;
        else if (ref_edge)         quiet_q <= '0;
        else if (quiet_q != LIMIT) quiet_q <= quiet_q + 1'b1;
    end

    assign ref_active = (quiet_q != LIMIT);
endmodule

// File: rtl/pmc_lock_timer.sv
module pmc_lock_timer #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0) && !load;
endmodule

// File: rtl/pmc_pclk_shaper.sv
module pmc_pclk_shaper #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic run,
    input  logic par_clk_in,
    output logic par_clk_out
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] PULSE = PW'(PULSE_CYC);

    logic [PW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_q <= '0;
        else if (wake)       low_q <= PULSE;
        else if (low_q != 0) low_q <= low_q - 1'b1;
    end

    always_comb begin
        if (low_q != '0) par_clk_out = 1'b0;
        else if (run)    par_clk_out = par_clk_in;
        else             par_clk_out = 1'b1;
    end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int IDLE_LIMIT = 16,
    parameter int COLD_WAIT  = 1024,
    parameter int WARM_WAIT  = 64,
    parameter int PULSE_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_pins,
    input  logic       ref_clk,
    input  logic       par_dir,
    input  logic       par_clk_in,
    output logic       pll_en,
    output logic       pll_bias_en,
    output logic       sio_en,
    output logic       data_valid,
    output logic       par_oe,
    output logic       par_clk_out
);
    localparam int TW = $clog2(COLD_WAIT + 1);
    localparam logic [TW-1:0] COLD_VAL = TW'(COLD_WAIT);
    localparam logic [TW-1:0] WARM_VAL = TW'(WARM_WAIT);

    pm_state_t     state_q, state_d;
    logic [1:0]    mode_s;
    logic          dir_s;
    logic          ref_active;
    logic          timer_load;
    logic [TW-1:0] timer_val;
    logic          timer_done;
    logic          wake;
    logic          mode_off;

    pmc_sync #(.WIDTH(2), .RST_VAL(1'b0)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .d(mode_pins), .q(mode_s)
    );

    pmc_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_dir_sync (
        .clk(clk), .rst_n(rst_n), .d(par_dir), .q(dir_s)
    );

    pmc_ref_monitor #(.IDLE_LIMIT(IDLE_LIMIT)) u_mon (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_active(ref_active)
    );

    pmc_lock_timer #(.WIDTH(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load),
        .load_val(timer_val), .done(timer_done)
    );

    assign mode_off = (mode_s == MODE_POWER_DOWN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_OFF;
        else        state_q <= state_d;
    end

    // Next state and timer loading
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = COLD_VAL;
        if (mode_off) begin
            state_d = PM_OFF;
        end else begin
            unique case (state_q)
                PM_OFF: begin
                    if (ref_active) begin
                        state_d    = PM_LOCK_COLD;
                        timer_load = 1'b1;
                        timer_val  = COLD_VAL;
                    end
                end
                PM_LOCK_COLD, PM_LOCK_WARM: begin
                    if (!ref_active)     state_d = PM_REF_STOP;
                    else if (timer_done) state_d = PM_RUN;
                end
                PM_RUN: begin
                    if (!ref_active) state_d = PM_REF_STOP;
                end
                PM_REF_STOP: begin
                    if (ref_active) begin
                        state_d    = PM_LOCK_WARM;
                        timer_load = 1'b1;
                        timer_val  = WARM_VAL;
                    end
                end
                default: state_d = PM_OFF;
            endcase
        end
    end

    assign wake = (state_q == PM_OFF) && (state_d == PM_LOCK_COLD);

    // Outputs decoded from the state
    always_comb begin
        pll_en      = 1'b0;
        pll_bias_en = 1'b0;
        sio_en      = 1'b0;
        data_valid  = 1'b0;
        unique case (state_q)
            PM_OFF: ;
            PM_LOCK_COLD, PM_LOCK_WARM: begin
                pll_en      = 1'b1;
                pll_bias_en = 1'b1;
                sio_en      = 1'b1;
            end
            PM_RUN: begin
                pll_en      = 1'b1;
                pll_bias_en = 1'b1;
                sio_en      = 1'b1;
                data_valid  = 1'b1;
            end
            PM_REF_STOP: pll_bias_en = 1'b1;
            default: ;
        endcase
        par_oe = !dir_s && (state_q != PM_OFF);
    end

    pmc_pclk_shaper #(.PULSE_CYC(PULSE_CYC)) u_pclk (
        .clk(clk), .rst_n(rst_n), .wake(wake),
        .run(state_q == PM_RUN), .par_clk_in(par_clk_in),
        .par_clk_out(par_clk_out)
    );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic clk,
    input logic rst_n,
    input logic par_dir,
    input logic ref_active,
    input logic pll_en,
    input logic pll_bias_en,
    input logic sio_en,
    input logic data_valid,
    input logic par_oe,
    input logic par_clk_out
);
    AST_OFF_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_bias_en |-> (!pll_en && !sio_en && !par_oe)); // R1

    AST_VALID_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (pll_en && sio_en)); // R9

    AST_STOP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pll_en) && pll_bias_en) |-> !$past(ref_active)); // R4

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> !$past(par_dir, 2)); // R8

    AST_PCLK_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_bias_en |-> par_clk_out); // R7

    AST_VALID_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(pll_en)); // R3
endmodule

bind pmc_top pmc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_dir    (par_dir),
    .ref_active (ref_active),
    .pll_en     (pll_en),
    .pll_bias_en(pll_bias_en),
    .sio_en     (sio_en),
    .data_valid (data_valid),
    .par_oe     (par_oe),
    .par_clk_out(par_clk_out)
);

// File: tb/tb_pmc_top.sv
`timescale 1ns/1ps
module tb_pmc_top;
    localparam int IDLE = 16;
    localparam int COLD = 40;
    localparam int WARM = 10;
    localparam int PULSE = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] mode_pins;
    logic ref_clk;
    logic par_dir;
    logic par_clk_in;
    logic pll_en, pll_bias_en, sio_en, data_valid, par_oe, par_clk_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit ref_run = 0;
    bit stop_req = 0;
    logic stop_lvl = 1'b0;
    int phase = 0;
    bit done_flag = 0;

    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pmc_top #(.IDLE_LIMIT(IDLE), .COLD_WAIT(COLD), .WARM_WAIT(WARM),
              .PULSE_CYC(PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .ref_clk(ref_clk),
        .par_dir(par_dir), .par_clk_in(par_clk_in), .pll_en(pll_en),
        .pll_bias_en(pll_bias_en), .sio_en(sio_en), .data_valid(data_valid),
        .par_oe(par_oe), .par_clk_out(par_clk_out)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push_wait(int cycles, string tag);
        exp_q.push_back(cycles);
        tag_q.push_back(tag);
    endtask

    // Reference generator: toggles every 3 cycles, can stop at a chosen level
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (ref_run) begin
                phase++;
                if (phase >= 3) begin
                    phase = 0;
                    ref_clk = ~ref_clk;
                    if (stop_req && ref_clk == stop_lvl) begin
                        ref_run  = 0;
                        stop_req = 0;
                    end
                end
            end
        end
    end

    // Monitor: measures lock waits and compares against the queue
    initial begin
        int start = 0;
        logic pe_prev = 1'b0;
        logic dv_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pll_en && !pe_prev) start = cyc;
                if (data_valid && !dv_prev) begin
                    n_tests++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R3/R5: unexpected data_valid rise, actual wait %0d expected none", cyc - start);
                    end else begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (cyc - start != e) begin
                            n_fail++;
                            $display("FAIL %s: lock wait actual %0d expected %0d", t, cyc - start, e);
                        end
                    end
                end
            end
            pe_prev = pll_en;
            dv_prev = data_valid;
        end
    end

    task automatic wait_sig_pll(string tag);
        for (int i = 0; i < 100 && !pll_en; i++) @(negedge clk);
        chk(tag, pll_en, 1'b1);
    endtask

    task automatic wait_valid(string tag);
        for (int i = 0; i < 200 && !data_valid; i++) @(negedge clk);
        chk(tag, data_valid, 1'b1);
    endtask

    task automatic stop_ref(logic lvl);
        stop_lvl = lvl;
        stop_req = 1;
        for (int i = 0; i < 20 && ref_run; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_pins = 2'b00; ref_clk = 0; par_dir = 1; par_clk_in = 1;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset pll_en", pll_en, 1'b0);
        chk("R1 reset bias", pll_bias_en, 1'b0);
        chk("R1 reset sio", sio_en, 1'b0);
        chk("R1 reset valid", data_valid, 1'b0);
        chk("R1 reset par_oe", par_oe, 1'b0);
        chk("R7 reset pclk", par_clk_out, 1'b1);

        // Reference running but mode 00 keeps everything off
        ref_run = 1;
        repeat (30) @(negedge clk);
        chk("R1 mode00 with ref pll_en", pll_en, 1'b0);
        chk("R1 mode00 with ref bias", pll_bias_en, 1'b0);

        // Cold start
        push_wait(COLD + 1, "R3");
        mode_pins = 2'b11;
        wait_sig_pll("R2 pll_en up");
        chk("R2 bias up", pll_bias_en, 1'b1);
        chk("R2 sio up", sio_en, 1'b1);
        for (int i = 0; i < PULSE; i++) begin
            chk("R7 wake low pulse", par_clk_out, 1'b0);
            @(negedge clk);
        end
        chk("R7 high after pulse", par_clk_out, 1'b1);
        chk("R3 no early valid", data_valid, 1'b0);
        wait_valid("R3 valid");
        par_clk_in = 0; #1;
        chk("R7 follows low", par_clk_out, 1'b0);
        par_clk_in = 1; #1;
        chk("R7 follows high", par_clk_out, 1'b1);

        // Direction control
        par_dir = 0;
        repeat (3) @(negedge clk);
        chk("R8 driven when dir low", par_oe, 1'b1);
        par_dir = 1;
        repeat (3) @(negedge clk);
        chk("R8 hi-z when dir high", par_oe, 1'b0);

        // Reference stalls high
        stop_ref(1'b1);
        repeat (12) @(negedge clk);
        chk("R4 no early stop", pll_en, 1'b1);
        repeat (20) @(negedge clk);
        chk("R4 stall high pll off", pll_en, 1'b0);
        chk("R4 stall high sio off", sio_en, 1'b0);
        chk("R4 stall high valid off", data_valid, 1'b0);
        chk("R4 stall high bias kept", pll_bias_en, 1'b1);
        chk("R7 stopped pclk high", par_clk_out, 1'b1);

        // Warm relock
        push_wait(WARM + 1, "R5");
        ref_run = 1;
        wait_sig_pll("R5 pll_en back");
        chk("R7 no pulse on warm relock", par_clk_out, 1'b1);
        wait_valid("R5 valid");

        // Reference stalls low, then power-down while stalled
        stop_ref(1'b0);
        repeat (32) @(negedge clk);
        chk("R4 stall low pll off", pll_en, 1'b0);
        chk("R4 stall low bias kept", pll_bias_en, 1'b1);
        mode_pins = 2'b00;
        repeat (4) @(negedge clk);
        chk("R1 off from stop bias", pll_bias_en, 1'b0);
        mode_pins = 2'b10;
        repeat (30) @(negedge clk);
        chk("R6 stays off pll", pll_en, 1'b0);
        chk("R6 stays off bias", pll_bias_en, 1'b0);
        push_wait(COLD + 1, "R6");
        ref_run = 1;
        wait_sig_pll("R6 pll_en on ref");
        chk("R6 cold pulse", par_clk_out, 1'b0);
        wait_valid("R6 valid");

        // Mode change between nonzero codes
        mode_pins = 2'b01;
        repeat (10) @(negedge clk);
        chk("R10 valid stays", data_valid, 1'b1);

        // Power-down while running, direction low
        par_dir = 0;
        repeat (3) @(negedge clk);
        chk("R8 driven in run", par_oe, 1'b1);
        mode_pins = 2'b00;
        repeat (4) @(negedge clk);
        chk("R1 run->off valid", data_valid, 1'b0);
        chk("R1 run->off pll", pll_en, 1'b0);
        chk("R1 run->off sio", sio_en, 1'b0);
        chk("R1 run->off bias", pll_bias_en, 1'b0);
        chk("R8 off forces hi-z", par_oe, 1'b0);

        // Mode 01 also enables, cold path again
        push_wait(COLD + 1, "R2");
        mode_pins = 2'b01;
        wait_valid("R2 mode01 valid");
        chk("R9 link up with valid", pll_en & sio_en, 1'b1);

        repeat (5) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R3/R5: pending waits actual %0d expected 0", exp_q.size());
        end
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule